// File: doc/BRIEF.md
# Multi-Domain Clock Enable Generator

This block turns one reference clock into six peripheral clock domains, each delivered as a one-cycle clock-enable strobe on the reference clock. Two power-of-two dividers set the rates. The main divider serves the local-bus, DMA, bridge, interrupt and host-port domains. A second divider serves the display domain. Each domain has its own rule for when it runs. That rule combines per-domain idle bits, per-domain enable bits, a global idle-mode request and, for the host port, an external DSP-idle input.

Software programs three small registers through a plain write and read port. A fourth read address returns which domains are running. The same running vector is also driven on a status output. Peripherals qualify their logic with their strobe, so no clock is ever cut mid-pulse.

Top module: `clkgate_unit`

## Requirements
- R1: While rst_n is low, ce_o and st_o are 0. After reset, address 0 reads 0x10, address 1 reads 0x00 and address 2 reads 0x07. So both dividers select divide-by-1, every idle bit is clear, every enable bit is set, and the interrupt domain follows the main divider.
- R2: The local-bus, DMA, bridge and host-port domains strobe once every 2^M reference cycles, where M is bits [1:0] of address 0. Running domains on the main divider strobe in the same cycle.
- R3: The display domain strobes once every 2^D reference cycles, where D is bits [3:2] of address 0. D is independent of M.
- R4: A new divider value is adopted only when the current divided period ends. The period in progress always completes at its old length.
- R5: The idle bits at address 1 act only while idle_req is high. One cycle after idle_req is low, every domain whose enable bits are set is running.
- R6: The local-bus domain (bit 0 of ce_o/st_o) runs only when address 2 bit 0 is set. It stops when address 1 bit 1 is set while idle_req is high.
- R7: The DMA domain (bit 1) runs only when address 2 bit 1 is set. It stops when address 1 bit 0 is set while idle_req is high.
- R8: The bridge domain (bit 2) is stopped only by address 1 bit 0 while idle_req is high.
- R9: The interrupt domain (bit 3) follows the main divider when address 0 bit 4 is 1, and strobes every reference cycle when that bit is 0. Like the bridge, it is stopped by address 1 bit 0 while idle_req is high.
- R10: The host-port domain (bit 4) stops only when address 1 bit 2, idle_req and dsp_idle are all high.
- R11: The display domain (bit 5) runs only when address 2 bit 2 is set. It stops when address 1 bit 3 is set while idle_req is high.
- R12: Outputs are registered and follow their inputs one cycle later. st_o and a read of address 3 (bits [5:0]) show the running domains. A strobe never appears on a domain shown as stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address (3 = running status) |
| rd_data | output | 8 | Register read data |
| idle_req | input | 1 | Global idle-mode request |
| dsp_idle | input | 1 | External DSP idle indication |
| ce_o | output | 6 | Per-domain clock-enable strobes |
| st_o | output | 6 | Per-domain running status |

## Verification
A divider counter or a latched divide value that goes wrong shows up as a strobe in the wrong cycle within one divided period, so within at most eight reference cycles. Wrong gating logic shows up on st_o and ce_o one cycle after the register write or input change that exposes it. A corrupted register shows up in the next read of that address. Because every output is registered, every fault of this kind becomes visible at a known cycle offset, and the bench compares ce_o, st_o and rd_data against its model on every cycle.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int SEL_W  = 2;
  localparam int N_DOM  = 6;
  localparam int N_DIV  = 2;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam int D_LB   = 0;
  localparam int D_DMA  = 1;
  localparam int D_BR   = 2;
  localparam int D_IRQ  = 3;
  localparam int D_HP   = 4;
  localparam int D_DISP = 5;

  localparam int DV_MAIN = 0;
  localparam int DV_DISP = 1;

  typedef struct packed {
    logic [SEL_W-1:0] main_div;
    logic [SEL_W-1:0] disp_div;
    logic             irq_main;
    logic             if_idle;
    logic             lb_idle;
    logic             hp_idle;
    logic             disp_idle;
    logic             lb_en;
    logic             dma_req;
    logic             disp_en;
  } cfg_t;
endpackage

// File: rtl/clkgate_div.sv
module clkgate_div
  import clkgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick_o
);
  localparam int CNT_W = (2 ** SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SEL_W-1:0] act_q, act_n;
  logic [CNT_W:0]   one_sh;
  logic [CNT_W-1:0] lim;

  always_comb begin
    one_sh = (CNT_W+1)'(1) << act_q;
    lim    = one_sh[CNT_W-1:0] - CNT_W'(1);
    tick_o = (cnt_q == lim);
    if (tick_o) begin
      cnt_n = '0;
      act_n = div_sel;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
      act_n = act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end
endmodule

// File: rtl/clkgate_regs.sv
module clkgate_regs
  import clkgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [N_DOM-1:0]  status,
  output logic [REG_W-1:0]  rd_data,
  output cfg_t              cfg_o
);
  cfg_t cfg_q, cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(0): begin
          cfg_n.main_div = wr_data[SEL_W-1:0];
          cfg_n.disp_div = wr_data[2*SEL_W-1:SEL_W];
          cfg_n.irq_main = wr_data[2*SEL_W];
        end
        ADDR_W'(1): begin
          cfg_n.if_idle   = wr_data[0];
          cfg_n.lb_idle   = wr_data[1];
          cfg_n.hp_idle   = wr_data[2];
          cfg_n.disp_idle = wr_data[3];
        end
        ADDR_W'(2): begin
          cfg_n.lb_en   = wr_data[0];
          cfg_n.dma_req = wr_data[1];
          cfg_n.disp_en = wr_data[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.main_div  <= '0;
      cfg_q.disp_div  <= '0;
      cfg_q.irq_main  <= 1'b1;
      cfg_q.if_idle   <= 1'b0;
      cfg_q.lb_idle   <= 1'b0;
      cfg_q.hp_idle   <= 1'b0;
      cfg_q.disp_idle <= 1'b0;
      cfg_q.lb_en     <= 1'b1;
      cfg_q.dma_req   <= 1'b1;
      cfg_q.disp_en   <= 1'b1;
    end else begin
      cfg_q <= cfg_n;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(0): rd_data[2*SEL_W:0] = {cfg_q.irq_main, cfg_q.disp_div, cfg_q.main_div};
      ADDR_W'(1): rd_data[3:0] = {cfg_q.disp_idle, cfg_q.hp_idle, cfg_q.lb_idle, cfg_q.if_idle};
      ADDR_W'(2): rd_data[2:0] = {cfg_q.disp_en, cfg_q.dma_req, cfg_q.lb_en};
      default:    rd_data[N_DOM-1:0] = status;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/clkgate_qual.sv
module clkgate_qual
  import clkgate_pkg::*;
(
  input  cfg_t             cfg,
  input  logic             idle_req,
  input  logic             dsp_idle,
  input  logic [N_DIV-1:0] tick,
  output logic [N_DOM-1:0] run_o,
  output logic [N_DOM-1:0] tick_o
);
  logic if_stop;

  always_comb begin
    if_stop = idle_req & cfg.if_idle;

    run_o[D_LB]   = cfg.lb_en & ~(idle_req & cfg.lb_idle);
    run_o[D_DMA]  = cfg.dma_req & ~if_stop;
    run_o[D_BR]   = ~if_stop;
    run_o[D_IRQ]  = ~if_stop;
    run_o[D_HP]   = ~(idle_req & cfg.hp_idle & dsp_idle);
    run_o[D_DISP] = cfg.disp_en & ~(idle_req & cfg.disp_idle);

    tick_o         = {N_DOM{tick[DV_MAIN]}};
    tick_o[D_IRQ]  = cfg.irq_main ? tick[DV_MAIN] : 1'b1;
    tick_o[D_DISP] = tick[DV_DISP];
  end
endmodule

// File: rtl/clkgate_unit.sv
module clkgate_unit
  import clkgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              idle_req,
  input  logic              dsp_idle,
  output logic [N_DOM-1:0]  ce_o,
  output logic [N_DOM-1:0]  st_o
);
  cfg_t             cfg_q;
  logic [SEL_W-1:0] div_sel [N_DIV];
  logic [N_DIV-1:0] tick;
  logic [N_DOM-1:0] run, dom_tick;
  logic [N_DOM-1:0] ce_q, ce_n, st_q, st_n;

  clkgate_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status(st_q),
    .rd_data(rd_data), .cfg_o(cfg_q)
  );

  assign div_sel[DV_MAIN] = cfg_q.main_div;
  assign div_sel[DV_DISP] = cfg_q.disp_div;

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    clkgate_div u_div (
      .clk(clk), .rst_n(rst_n), .div_sel(div_sel[g]), .tick_o(tick[g])
    );
  end

  clkgate_qual u_qual (
    .cfg(cfg_q), .idle_req(idle_req), .dsp_idle(dsp_idle),
    .tick(tick), .run_o(run), .tick_o(dom_tick)
  );

  always_comb begin
    st_n = run;
    ce_n = run & dom_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= '0;
      st_q <= '0;
    end else begin
      ce_q <= ce_n;
      st_q <= st_n;
    end
  end

  assign ce_o = ce_q;
  assign st_o = st_q;
endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk
  import clkgate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             idle_req,
  input logic             dsp_idle,
  input logic             irq_main,
  input logic             if_idle,
  input logic [N_DOM-1:0] ce_o,
  input logic [N_DOM-1:0] st_o
);
  // R5
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> st_o[D_BR]);

  // R8
  bridge_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && if_idle) |=> !st_o[D_BR]);

  // R10
  hp_dsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_idle |=> st_o[D_HP]);

  // R12
  ce_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_o & ~st_o) == '0);

  // R2
  main_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o[D_BR] && st_o[D_LB]) |-> (ce_o[D_BR] == ce_o[D_LB]));

  // R9
  irq_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o[D_IRQ] && !$past(irq_main)) |-> ce_o[D_IRQ]);
endmodule

bind clkgate_unit clkgate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .dsp_idle(dsp_idle),
  .irq_main(cfg_q.irq_main), .if_idle(cfg_q.if_idle),
  .ce_o(ce_o), .st_o(st_o)
);

// File: tb/sim_clkgate_unit.sv
module sim_clkgate_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       idle_req = 1'b0;
  logic       dsp_idle = 1'b0;
  logic [5:0] ce_o, st_o;

  int total = 0;
  int bad = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;

  clkgate_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .idle_req(idle_req), .dsp_idle(dsp_idle), .ce_o(ce_o), .st_o(st_o)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_cnt [2];
  int m_act [2];
  int m_mdiv, m_ddiv;
  bit m_irq, m_ifi, m_lbi, m_hpi, m_dpi, m_lben, m_dmar, m_dpen;
  logic [5:0] exp_ce, exp_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_act[k] = 0; end
      m_mdiv = 0; m_ddiv = 0; m_irq = 1;
      m_ifi = 0; m_lbi = 0; m_hpi = 0; m_dpi = 0;
      m_lben = 1; m_dmar = 1; m_dpen = 1;
      exp_ce = '0; exp_st = '0;
    end else begin
      bit tk [2];
      bit stop_if;
      for (int k = 0; k < 2; k++) tk[k] = (m_cnt[k] == (1 << m_act[k]) - 1);
      stop_if = idle_req && m_ifi;
      exp_st[0] = m_lben && !(idle_req && m_lbi);
      exp_st[1] = m_dmar && !stop_if;
      exp_st[2] = !stop_if;
      exp_st[3] = !stop_if;
      exp_st[4] = !(idle_req && m_hpi && dsp_idle);
      exp_st[5] = m_dpen && !(idle_req && m_dpi);
      exp_ce[0] = exp_st[0] && tk[0];
      exp_ce[1] = exp_st[1] && tk[0];
      exp_ce[2] = exp_st[2] && tk[0];
      exp_ce[3] = exp_st[3] && (m_irq ? tk[0] : 1'b1);
      exp_ce[4] = exp_st[4] && tk[0];
      exp_ce[5] = exp_st[5] && tk[1];
      for (int k = 0; k < 2; k++) begin
        if (tk[k]) begin
          m_cnt[k] = 0;
          m_act[k] = (k == 0) ? m_mdiv : m_ddiv;
        end else m_cnt[k] = m_cnt[k] + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_mdiv = wr_data[1:0]; m_ddiv = wr_data[3:2]; m_irq = wr_data[4]; end
          2'd1: begin m_ifi = wr_data[0]; m_lbi = wr_data[1]; m_hpi = wr_data[2]; m_dpi = wr_data[3]; end
          2'd2: begin m_lben = wr_data[0]; m_dmar = wr_data[1]; m_dpen = wr_data[2]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {3'b0, m_irq, 2'(m_ddiv), 2'(m_mdiv)};
      2'd1: return {4'b0, m_dpi, m_hpi, m_lbi, m_ifi};
      2'd2: return {5'b0, m_dpen, m_dmar, m_lben};
      default: return {2'b0, exp_st};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      check({phase, " ce_o"}, 32'(ce_o), 32'(exp_ce));
      check({phase, " st_o"}, 32'(st_o), 32'(exp_st));
      check({phase, " rd_data"}, 32'(rd_data), 32'(exp_rd(rd_addr)));
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_ce(int dom, int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      if (ce_o[dom]) c++;
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, gap;
    // R1 reset state
    cyc(3);
    check("R1 ce_o in reset", 32'(ce_o), 0);
    check("R1 st_o in reset", 32'(st_o), 0);
    rd_addr = 2'd0; #1; check("R1 ctrl reset", 32'(rd_data), 32'h10);
    rd_addr = 2'd1; #1; check("R1 idle reset", 32'(rd_data), 32'h00);
    rd_addr = 2'd2; #1; check("R1 enable reset", 32'(rd_data), 32'h07);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;
    cyc(2);
    check("R1 all domains strobe at divide-by-1", 32'(ce_o), 32'h3f);

    // R2 main divider /4
    phase = "R2"; rd_addr = 2'd3;
    wr(2'd0, 8'h12); cyc(12);
    count_ce(2, 40, c); check("R2 bridge strobes over 40 at /4", c, 10);
    count_ce(4, 40, c); check("R2 host port strobes over 40 at /4", c, 10);

    // R3 display divider /8, main /2
    phase = "R3";
    wr(2'd0, 8'h1d); cyc(16);
    count_ce(5, 64, c); check("R3 display strobes over 64 at /8", c, 8);
    count_ce(1, 64, c); check("R3 dma strobes over 64 at /2", c, 32);

    // R4 boundary: /8 then switch to /1 mid-period
    phase = "R4";
    wr(2'd0, 8'h13); cyc(16);
    while (!ce_o[2]) @(negedge clk);
    wr(2'd0, 8'h10);
    gap = 1;
    while (!ce_o[2]) begin @(negedge clk); gap++; end
    check("R4 old period completes", gap, 8);
    @(negedge clk);
    check("R4 new divide-by-1 follows", 32'(ce_o[2]), 1);

    // R5 idle bits gated by idle_req
    phase = "R5"; rd_addr = 2'd1;
    dsp_idle = 1'b1;
    wr(2'd1, 8'h0f); cyc(1);
    check("R5 idle bits without request", 32'(st_o), 32'h3f);
    idle_req = 1'b1; cyc(1);
    check("R5 all stop under request", 32'(st_o), 32'h00);
    check("R5 no strobes under request", 32'(ce_o), 32'h00);
    idle_req = 1'b0; cyc(1);
    check("R5 resume after request drops", 32'(st_o), 32'h3f);

    // R8 shared interface idle only
    phase = "R8"; rd_addr = 2'd3;
    wr(2'd1, 8'h01); idle_req = 1'b1; cyc(1);
    check("R8 shared idle stops bridge dma irq", 32'(st_o), 32'h31);
    rd_addr = 2'd3; #1;
    check("R12 status read matches", 32'(rd_data), 32'h31);
    idle_req = 1'b0; cyc(2);

    // R6 local bus
    phase = "R6";
    wr(2'd1, 8'h02); idle_req = 1'b1; cyc(1);
    check("R6 local bus idle stops it", 32'(st_o), 32'h3e);
    idle_req = 1'b0; wr(2'd1, 8'h00); wr(2'd2, 8'h06); cyc(1);
    check("R6 local bus enable clear", 32'(st_o), 32'h3e);

    // R7 DMA request
    phase = "R7";
    wr(2'd2, 8'h05); cyc(1);
    check("R7 dma request clear", 32'(st_o), 32'h3d);

    // R11 display
    phase = "R11";
    wr(2'd2, 8'h03); cyc(1);
    check("R11 display enable clear", 32'(st_o), 32'h1f);
    wr(2'd2, 8'h07); wr(2'd1, 8'h08); idle_req = 1'b1; cyc(1);
    check("R11 display idle stops it", 32'(st_o), 32'h1f);
    idle_req = 1'b0; cyc(1);

    // R10 host port
    phase = "R10";
    wr(2'd1, 8'h04); dsp_idle = 1'b0; idle_req = 1'b1; cyc(2);
    check("R10 host port runs without dsp idle", 32'(st_o[4]), 1);
    dsp_idle = 1'b1; cyc(1);
    check("R10 host port stops with all three", 32'(st_o[4]), 0);
    idle_req = 1'b0; cyc(1);
    check("R10 host port resumes", 32'(st_o[4]), 1);
    wr(2'd1, 8'h00);

    // R9 interrupt select
    phase = "R9";
    wr(2'd0, 8'h02); cyc(10);
    count_ce(3, 16, c); check("R9 irq at reference rate", c, 16);
    count_ce(2, 16, c); check("R9 bridge stays at /4", c, 4);
    wr(2'd0, 8'h12); cyc(10);
    count_ce(3, 16, c); check("R9 irq follows main /4", c, 4);

    // R12 status and strobe consistency over a mixed run
    phase = "R12";
    wr(2'd1, 8'h05); dsp_idle = 1'b1; idle_req = 1'b1; cyc(2);
    check("R12 st_o mixed", 32'(st_o), 32'h21);
    check("R12 no strobe on stopped domain", 32'(ce_o & ~st_o), 0);
    idle_req = 1'b0; cyc(4);

    cmp_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule